// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits next to a small processor core. It arbitrates between a reset request and a set of interrupt request lines, and hands the core one vector address together with a one-cycle take strobe. Each source has its own enable bit, and a single global enable flag gates all maskable sources. When the controller issues a vector, it drops the global enable flag in the same clock edge. Any further interrupt, nested or not, waits until software sets the flag again or returns from the handler.

Priority is fixed by vector slot. Reset owns slot 0 at the base address. Source 0 owns slot 1, source 1 owns slot 2, and so on. A lower slot always wins. Each request is caught in a per-source pending flag, so a one-cycle pulse is not lost while the source is masked.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After the synchronous block reset `rst`, `take` is 0, `vec_addr` equals VEC_BASE, `glb_en` is 0, `src_en` is all zeros, and no pending request remains.
- R2: The vector for source i is VEC_BASE + (i+1)*SLOT_SIZE. The vector for a reset request is VEC_BASE. `vec_addr` holds that value in the cycle where `take` is 1.
- R3: Source i can be issued only while its pending flag, `src_en[i]` and `glb_en` are all 1. With `glb_en` at 0 or the source's enable bit at 0, `take` stays 0.
- R4: Among the eligible sources, the one with the lowest index is issued. A reset request outranks every source.
- R5: `take` is high for exactly one cycle per issue. The edge that raises `take` also clears `glb_en`. At most one vector is issued per cycle.
- R6: A request pulse sets the source's pending flag, and the flag holds until that source is issued. Issuing a source clears only that source's flag, and other pending sources stay pending.
- R7: A request sampled at clock edge k produces `take` after edge k+1, provided the source is eligible at edge k+1. Immediately after edge k, `take` is still 0.
- R8: `glb_clr` clears `glb_en`. `glb_set` or `ret_strobe` sets it. `glb_clr` wins over a set in the same cycle. An issue in the same cycle wins over both, leaving `glb_en` at 0.
- R9: A rising edge of `rst_req` produces `take` with vector VEC_BASE one edge later. While `rst_req` is high:
  - `glb_en`, all enable bits and all pending flags are cleared.
  - Enable writes are ignored.
  - No source is issued, and no second `take` occurs.
- R10: With `en_we` high, `src_en` loads `en_wdata` at the next edge. Bit i of the data enables source i.
- R11: After an issue, setting `glb_en` again (via `ret_strobe` or `glb_set`) lets the next-highest pending source be issued two edges after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_req | input | 1 | Reset request (non-maskable, vector slot 0) |
| irq_req | input | N_SRC | Interrupt request lines; bit i is source i |
| en_we | input | 1 | Write strobe for the per-source enable register |
| en_wdata | input | N_SRC | New per-source enable bits |
| glb_set | input | 1 | Set the global enable flag |
| glb_clr | input | 1 | Clear the global enable flag |
| ret_strobe | input | 1 | Return from interrupt; sets the global enable flag |
| take | output | 1 | One-cycle strobe: a vector is being issued |
| vec_addr | output | 16 | Vector address of the last issue |
| glb_en | output | 1 | Current global enable flag |
| src_en | output | N_SRC | Current per-source enable bits |

## Verification
On every cycle, the assertions check four things:
- The take strobe never lasts two cycles, except when a reset vector follows an interrupt.
- The global flag is low whenever a vector is issued.
- Every issued vector sits on the slot grid.
- Every issued source was eligible one cycle earlier, and no lower-indexed source was eligible at that time.

They also check that a reset request wipes the enables, the flag and the pending state. Only the bench scenarios can show the following:
- The exact vector chosen for every combination of enables and requests.
- The two-edge latency.
- That a masked pulse is remembered.
- The precedence among set, clear and issue on the global flag.
- That returning from a handler releases the next pending source.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int VADDR_W = 16;

    typedef logic [VADDR_W-1:0] vaddr_t;

    typedef enum logic [1:0] {
        ISS_NONE  = 2'd0,
        ISS_RESET = 2'd1,
        ISS_IRQ   = 2'd2
    } iss_kind_e;

    typedef struct packed {
        logic      take;
        iss_kind_e kind;
        vaddr_t    addr;
    } issue_t;

    // Address of vector slot 'slot_idx' (slot 0 belongs to reset).
    function automatic vaddr_t slot_addr(vaddr_t base, int unsigned slot_size,
                                         int unsigned slot_idx);
        return base + vaddr_t'(slot_size * slot_idx);
    endfunction
endpackage

// File: rtl/vic_pending.sv
module vic_pending #(
    parameter int unsigned N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wipe,
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] clr,
    output logic [N_SRC-1:0] pend
);
    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst || wipe)
                    pend[g] <= 1'b0;
                else
                    pend[g] <= (pend[g] & ~clr[g]) | req[g];
            end
        end
    endgenerate
endmodule

// File: rtl/vic_mask_regs.sv
module vic_mask_regs #(
    parameter int unsigned N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wipe,
    input  logic             en_we,
    input  logic [N_SRC-1:0] en_wdata,
    input  logic             glb_set,
    input  logic             glb_clr,
    input  logic             accept,
    output logic [N_SRC-1:0] en_q,
    output logic             glb_q
);
    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            en_q  <= '0;
            glb_q <= 1'b0;
        end else begin
            if (en_we)
                en_q <= en_wdata;
            // issue beats explicit clear, which beats set
            if (accept)
                glb_q <= 1'b0;
            else if (glb_clr)
                glb_q <= 1'b0;
            else if (glb_set)
                glb_q <= 1'b1;
        end
    end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
    parameter int unsigned N_SRC  = 4,
    parameter int unsigned SIDX_W = 2
) (
    input  logic [N_SRC-1:0]  elig,
    output logic [N_SRC-1:0]  grant,
    output logic              valid,
    output logic [SIDX_W-1:0] idx
);
    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_grant
            if (g == 0) begin : g_top
                assign grant[g] = elig[g];
            end else begin : g_rest
                assign grant[g] = elig[g] & ~(|elig[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int j = 0; j < int'(N_SRC); j++) begin
            if (grant[j])
                idx = idx | SIDX_W'(j);
        end
    end

    assign valid = |elig;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int unsigned N_SRC     = 4,
    parameter int unsigned SLOT_SIZE = 2,
    parameter vaddr_t      VEC_BASE  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_req,
    input  logic [N_SRC-1:0] irq_req,
    input  logic             en_we,
    input  logic [N_SRC-1:0] en_wdata,
    input  logic             glb_set,
    input  logic             glb_clr,
    input  logic             ret_strobe,
    output logic             take,
    output logic [15:0]      vec_addr,
    output logic             glb_en,
    output logic [N_SRC-1:0] src_en
);
    localparam int unsigned SIDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [N_SRC-1:0]  pend_q;
    logic [N_SRC-1:0]  elig;
    logic [N_SRC-1:0]  grant;
    logic [N_SRC-1:0]  clr_vec;
    logic              win_valid;
    logic [SIDX_W-1:0] win_idx;
    logic              accept;
    logic              rst_d;
    logic              rst_edge;
    issue_t            iss_q;
    vaddr_t            win_addr;

    assign rst_edge = rst_req & ~rst_d;
    assign elig     = pend_q & src_en & {N_SRC{glb_en}};
    assign accept   = win_valid & ~rst_req;
    assign clr_vec  = accept ? grant : '0;
    assign win_addr = slot_addr(VEC_BASE, SLOT_SIZE, 32'(win_idx) + 32'd1);

    vic_pending #(.N_SRC(N_SRC)) u_pend (
        .clk  (clk),
        .rst  (rst),
        .wipe (rst_req),
        .req  (irq_req),
        .clr  (clr_vec),
        .pend (pend_q)
    );

    vic_mask_regs #(.N_SRC(N_SRC)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wipe     (rst_req),
        .en_we    (en_we),
        .en_wdata (en_wdata),
        .glb_set  (glb_set | ret_strobe),
        .glb_clr  (glb_clr),
        .accept   (accept),
        .en_q     (src_en),
        .glb_q    (glb_en)
    );

    vic_arbiter #(.N_SRC(N_SRC), .SIDX_W(SIDX_W)) u_arb (
        .elig  (elig),
        .grant (grant),
        .valid (win_valid),
        .idx   (win_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_d <= 1'b0;
            iss_q <= '{take: 1'b0, kind: ISS_NONE, addr: VEC_BASE};
        end else begin
            rst_d <= rst_req;
            if (rst_edge)
                iss_q <= '{take: 1'b1, kind: ISS_RESET, addr: VEC_BASE};
            else if (accept)
                iss_q <= '{take: 1'b1, kind: ISS_IRQ, addr: win_addr};
            else begin
                iss_q.take <= 1'b0;
                iss_q.kind <= ISS_NONE;
            end
        end
    end

    assign take     = iss_q.take;
    assign vec_addr = iss_q.addr;
endmodule

// File: rtl/vic_chk.sv
module vic_chk
    import vic_pkg::*;
#(
    parameter int unsigned N_SRC     = 4,
    parameter int unsigned SLOT_SIZE = 2,
    parameter vaddr_t      VEC_BASE  = '0
) (
    input logic             clk,
    input logic             rst,
    input logic             rst_req,
    input logic             take,
    input logic [15:0]      vec_addr,
    input logic             glb_en,
    input logic [N_SRC-1:0] src_en,
    input logic [N_SRC-1:0] pend
);
    logic [N_SRC-1:0] elig_d;
    logic [31:0]      off;
    logic [31:0]      slot_k;
    logic             was_elig;
    logic             lower_free;

    always_ff @(posedge clk)
        elig_d <= pend & src_en & {N_SRC{glb_en}};

    assign off    = 32'(vec_addr) - 32'(VEC_BASE);
    assign slot_k = off / SLOT_SIZE;

    always_comb begin
        was_elig   = 1'b0;
        lower_free = 1'b1;
        for (int j = 0; j < int'(N_SRC); j++) begin
            if (slot_k == 32'(j) + 32'd1)
                was_elig = elig_d[j];
            if (32'(j) + 32'd1 < slot_k && elig_d[j])
                lower_free = 1'b0;
        end
    end

    AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        take |=> (!take || vec_addr == VEC_BASE));                     // R5
    AST_GLB_DROPPED: assert property (@(posedge clk) disable iff (rst)
        take |-> !glb_en);                                             // R5
    AST_RESET_WIPES: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> (!glb_en && src_en == '0 && pend == '0));          // R9
    AST_VEC_ON_GRID: assert property (@(posedge clk) disable iff (rst)
        take |-> (off % SLOT_SIZE == 0 && slot_k <= N_SRC));           // R2
    AST_ISSUE_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        (take && vec_addr != VEC_BASE) |-> was_elig);                  // R3
    AST_ISSUE_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (take && vec_addr != VEC_BASE) |-> lower_free);                // R4
endmodule

bind vec_irq_ctrl vic_chk #(
    .N_SRC(N_SRC), .SLOT_SIZE(SLOT_SIZE), .VEC_BASE(VEC_BASE)
) u_chk (
    .clk(clk), .rst(rst), .rst_req(rst_req), .take(take),
    .vec_addr(vec_addr), .glb_en(glb_en), .src_en(src_en), .pend(pend_q)
);

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
    localparam int N = 4;
    localparam int SLOT = 2;

    logic         clk = 1'b0;
    logic         rst, rst_req, en_we, glb_set, glb_clr, ret_strobe;
    logic [N-1:0] irq_req, en_wdata;
    logic         take, glb_en;
    logic [15:0]  vec_addr;
    logic [N-1:0] src_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vec_irq_ctrl #(.N_SRC(N), .SLOT_SIZE(SLOT), .VEC_BASE(16'h0)) dut (
        .clk(clk), .rst(rst), .rst_req(rst_req), .irq_req(irq_req),
        .en_we(en_we), .en_wdata(en_wdata), .glb_set(glb_set),
        .glb_clr(glb_clr), .ret_strobe(ret_strobe), .take(take),
        .vec_addr(vec_addr), .glb_en(glb_en), .src_en(src_en)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    function automatic int lowest(input logic [N-1:0] m);
        for (int i = 0; i < N; i++)
            if (m[i]) return i;
        return -1;
    endfunction

    task automatic idle_inputs();
        rst_req = 0; en_we = 0; glb_set = 0; glb_clr = 0; ret_strobe = 0;
        irq_req = '0; en_wdata = '0;
    endtask

    task automatic do_reset();
        rst = 1;
        step();
        rst = 0;
    endtask

    initial begin
        rst = 1;
        idle_inputs();
        step();
        step();
        rst = 0;
        // R1: state after block reset
        chk(take == 0, "R1 take", int'(take), 0);
        chk(vec_addr == 0, "R1 vec", int'(vec_addr), 0);
        chk(glb_en == 0, "R1 glb_en", int'(glb_en), 0);
        chk(src_en == 0, "R1 src_en", int'(src_en), 0);

        // Sweep every enable mask against every request mask
        for (int em = 0; em < 16; em++) begin
            for (int rm = 0; rm < 16; rm++) begin
                int w, w2;
                logic [N-1:0] rem;
                do_reset();
                en_we = 1; en_wdata = N'(em); glb_set = 1;
                step();
                en_we = 0; glb_set = 0;
                chk(src_en == N'(em), "R10 enable load", int'(src_en), em);
                irq_req = N'(rm);
                step();
                irq_req = '0;
                chk(take == 0, "R7 no take one edge after request", int'(take), 0);
                step();
                w = lowest(N'(rm & em));
                if (w >= 0) begin
                    chk(take == 1, "R4 take", int'(take), 1);
                    chk(vec_addr == 16'((w + 1) * SLOT), "R2/R4 vector", int'(vec_addr), (w + 1) * SLOT);
                    chk(glb_en == 0, "R5 glb_en cleared on issue", int'(glb_en), 0);
                end else begin
                    chk(take == 0, "R3 masked sources not issued", int'(take), 0);
                end
                step();
                chk(take == 0, "R5 single-cycle take", int'(take), 0);
                if (w >= 0) begin
                    rem = N'(rm) & ~(N'(1) << w);
                    ret_strobe = 1;
                    step();
                    ret_strobe = 0;
                    chk(take == 0, "R11 no take on return edge", int'(take), 0);
                    step();
                    w2 = lowest(rem & N'(em));
                    if (w2 >= 0) begin
                        chk(take == 1 && vec_addr == 16'((w2 + 1) * SLOT),
                            "R6/R11 next pending vector", int'(vec_addr), (w2 + 1) * SLOT);
                    end else begin
                        chk(take == 0, "R6 issued flag cleared", int'(take), 0);
                    end
                end
            end
        end

        // R6: request while global flag is low is remembered
        do_reset();
        en_we = 1; en_wdata = 4'b0100;
        irq_req = 4'b0100;
        step();
        en_we = 0; irq_req = '0;
        step(); step(); step();
        chk(take == 0, "R3 held off while glb_en low", int'(take), 0);
        glb_set = 1;
        step();
        glb_set = 0;
        step();
        chk(take == 1 && vec_addr == 16'(3 * SLOT), "R6 latched pulse issued", int'(vec_addr), 3 * SLOT);

        // R8: clear wins over set; set alone works
        do_reset();
        glb_set = 1; glb_clr = 1;
        step();
        glb_set = 0; glb_clr = 0;
        chk(glb_en == 0, "R8 clear beats set", int'(glb_en), 0);
        glb_set = 1;
        step();
        glb_set = 0;
        chk(glb_en == 1, "R8 set", int'(glb_en), 1);
        glb_clr = 1;
        step();
        glb_clr = 0;
        chk(glb_en == 0, "R8 clear", int'(glb_en), 0);

        // R8: issue beats set in the same cycle
        do_reset();
        en_we = 1; en_wdata = 4'b0001; glb_set = 1; irq_req = 4'b0001;
        step();
        en_we = 0; irq_req = '0;
        step();
        glb_set = 0;
        chk(take == 1 && glb_en == 0, "R8 issue beats set", int'(glb_en), 0);

        // R9: reset request
        do_reset();
        en_we = 1; en_wdata = 4'b1111; glb_set = 1;
        step();
        en_we = 0; glb_set = 0;
        irq_req = 4'b0011;
        step();
        irq_req = '0;
        rst_req = 1;
        step();
        chk(take == 1 && vec_addr == 0, "R9 reset vector", int'(vec_addr), 0);
        chk(glb_en == 0 && src_en == 0, "R9 wipes enables", int'(src_en), 0);
        en_we = 1; en_wdata = 4'b1111; glb_set = 1;
        step();
        en_we = 0; glb_set = 0;
        chk(take == 0, "R9 no second take while held", int'(take), 0);
        chk(src_en == 0, "R9 enable write ignored", int'(src_en), 0);
        step();
        rst_req = 0;
        en_we = 1; en_wdata = 4'b1111; glb_set = 1;
        step();
        en_we = 0; glb_set = 0;
        step(); step();
        chk(take == 0, "R9 pending wiped", int'(take), 0);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end
endmodule